// File: doc/BRIEF.md
# Two-Source Output Route Arbiter

This block connects one of two upstream message validators to one of several output channels. While no route is open it looks at one requester per clock, alternating between the two. When the requester it is looking at has a request pending, the arbiter grants it the shared bus. The requester's destination address is then turned into a one-hot select toward the addressed channel. The moving of message bytes is not part of this block.

Once a channel is selected, it answers with its own module address and a flag that says whether it has a free buffer. The arbiter signals destination-ready to the requester only when that returned address equals the requested one and a buffer is free. The route then stays open until the requester withdraws its address-valid line.

A wrong returned address, or an address beyond the last channel, closes the attempt and raises a one-cycle route-error pulse. A channel whose buffers are all occupied makes the arbiter turn to the other requester rather than wait. The request that was turned away stays pending and is tried again on its next turn.

Top module: `dual_path_arbiter`

## Requirements
- R1: After reset, `grant_o`, `sel_o`, `dst_rdy_o` and `route_err_o` are all zero.
- R2: With no route open, the arbiter examines one requester per clock, alternating between them. After any service, refusal or error, the next requester examined is the other one. `grant_o` bit n (bit 0 = requester 0, bit 1 = requester 1) goes high the cycle after requester n is found requesting.
- R3: While granted, the clock edge that sees the owner's `avld_i` bit high with an in-range address latches that address. From the next cycle `sel_o` is one-hot, and its set bit index equals the address.
- R4: On the first select cycle, if `ch_addr_i` equals the latched address and `ch_free_i` is 1, then from the next cycle `dst_rdy_o` equals the owner's grant bit. It stays high while the owner holds `avld_i`.
- R5: If `ch_free_i` is 0 on the first select cycle, grant and select drop the next cycle, with no ready and no error. The request stays pending and is retried on its next turn, so the other requester may be served in between.
- R6: If `ch_addr_i` differs from the latched address on the first select cycle, grant and select drop the next cycle. `route_err_o` pulses for exactly that cycle and no ready is given.
- R7: An address of `NCH` or above (with defaults, 5, 6 or 7) is refused with a `route_err_o` pulse. No `sel_o` bit is ever raised for it.
- R8: The cycle after the owner drops its `avld_i` bit during a transfer, `dst_rdy_o`, `grant_o` and `sel_o` return to zero.
- R9: When both requesters keep requesting, successive completed services alternate between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Service request, one bit per requester |
| dst0_i | input | AW | Destination address of requester 0 |
| dst1_i | input | AW | Destination address of requester 1 |
| avld_i | input | 2 | Address valid / transfer active, one bit per requester |
| ch_addr_i | input | AW | Module address returned by the selected channel |
| ch_free_i | input | 1 | Selected channel reports a free buffer |
| grant_o | output | 2 | Bus grant, one bit per requester |
| sel_o | output | NCH | One-hot channel select |
| dst_rdy_o | output | 2 | Destination ready, one bit per requester |
| route_err_o | output | 1 | One-cycle pulse on a refused or mismatched route |

## Verification
The checks assume that a requester keeps its address stable and its request high from the moment it raises them until it is served or refused. They also assume that a selected channel answers within the same cycle, and that only the granted requester's lines matter. The stimulus changes requester lines only on the falling edge. It raises request and address-valid together and drops them together after ready has been seen. Where the polling phase is not known, it raises the second requester only after the first has been granted, or builds its expected order from the first grant it observes. A refused requester drops its request before its turn comes round again, except in the full-buffer case, where the retry is the behaviour under test.

// File: rtl/dual_path_arbiter.sv
module dual_path_arbiter #(
  parameter int NCH = 5,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req_i,
  input  logic [AW-1:0] dst0_i,
  input  logic [AW-1:0] dst1_i,
  input  logic [1:0]    avld_i,
  input  logic [AW-1:0] ch_addr_i,
  input  logic          ch_free_i,
  output logic [1:0]    grant_o,
  output logic [NCH-1:0] sel_o,
  output logic [1:0]    dst_rdy_o,
  output logic          route_err_o
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NCH);

  typedef enum logic [1:0] {IDLE, WAIT, ROUTE, XFER} st_t;
  st_t st;
  logic turn, own;
  logic [AW-1:0] addr_q;

  wire [AW-1:0] own_dst = own ? dst1_i : dst0_i;
  wire own_vld  = avld_i[own];
  wire in_range = {1'b0, own_dst} < LIMIT;
  wire routed   = (st == ROUTE) || (st == XFER);

  assign grant_o   = (st == IDLE) ? 2'b00 : (own ? 2'b10 : 2'b01);
  assign dst_rdy_o = (st == XFER) ? grant_o : 2'b00;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel_o[i] = routed && (addr_q == AW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      turn        <= 1'b0;
      own         <= 1'b0;
      addr_q      <= '0;
      route_err_o <= 1'b0;
    end else begin
      route_err_o <= 1'b0;
      case (st)
        IDLE:
          if (req_i[turn]) begin
            own <= turn;
            st  <= WAIT;
          end else begin
            turn <= ~turn;
          end
        WAIT:
          if (own_vld) begin
            if (in_range) begin
              addr_q <= own_dst;
              st     <= ROUTE;
            end else begin
              route_err_o <= 1'b1;
              turn        <= ~own;
              st          <= IDLE;
            end
          end
        ROUTE:
          if (ch_addr_i != addr_q) begin
            route_err_o <= 1'b1;
            turn        <= ~own;
            st          <= IDLE;
          end else if (!ch_free_i) begin
            turn <= ~own;
            st   <= IDLE;
          end else begin
            st <= XFER;
          end
        default:
          if (!own_vld) begin
            turn <= ~own;
            st   <= IDLE;
          end
      endcase
    end
  end

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  // R4
  rdy_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dst_rdy_o) |-> ($past(ch_free_i) && ($past(ch_addr_i) == addr_q)));

  // R5
  full_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ROUTE && ch_addr_i == addr_q && !ch_free_i) |=>
      (dst_rdy_o == 2'b00 && grant_o == 2'b00 && !route_err_o));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_err_o |-> (sel_o == '0 && dst_rdy_o == 2'b00 && grant_o == 2'b00));

  // R7
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && own_vld && !in_range) |=> (route_err_o && sel_o == '0));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dst_rdy_o) && !(|(avld_i & dst_rdy_o))) |=> (dst_rdy_o == 2'b00 && sel_o == '0));
endmodule

// File: tb/dual_path_arbiter_test.sv
module dual_path_arbiter_test;
  localparam int NCH = 5;
  localparam int AW = 3;
  localparam int CLK_PERIOD = 10;
  localparam int K_DONE = 0, K_YIELD = 1, K_ERR = 2, NONE = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req_i = '0, avld_i = '0;
  logic [AW-1:0] dst0_i = '0, dst1_i = '0;
  logic [AW-1:0] ch_addr_i;
  logic ch_free_i;
  logic [1:0] grant_o, dst_rdy_o;
  logic [NCH-1:0] sel_o;
  logic route_err_o;

  logic corrupt = 1'b0;
  logic [NCH-1:0] full = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { bit own; int ch; int kind; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_path_arbiter #(.NCH(NCH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .dst0_i(dst0_i), .dst1_i(dst1_i),
    .avld_i(avld_i), .ch_addr_i(ch_addr_i), .ch_free_i(ch_free_i),
    .grant_o(grant_o), .sel_o(sel_o), .dst_rdy_o(dst_rdy_o), .route_err_o(route_err_o));

  always_comb begin
    ch_addr_i = '0;
    ch_free_i = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (sel_o[i]) begin
        ch_addr_i = AW'(i) ^ AW'(corrupt);
        ch_free_i = !full[i];
      end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit o, input int ch, input int k, input string tag);
    exp_t e;
    e.own = o; e.ch = ch; e.kind = k; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // monitor: one result per closed route
  logic [1:0] pg = '0, pr = '0;
  logic [NCH-1:0] ps = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pg != 2'b00 && grant_o == 2'b00) begin
        automatic int ch = NONE;
        automatic int k;
        automatic exp_t e;
        for (int i = 0; i < NCH; i++) if (ps[i]) ch = i;
        k = (pr != 2'b00) ? K_DONE : (route_err_o ? K_ERR : K_YIELD);
        if (q.size() == 0) begin
          check(0, "unexpected route closure", k, -1);
        end else begin
          e = q.pop_front();
          check(pg[1] == e.own, {e.tag, " owner"}, int'(pg[1]), int'(e.own));
          check(ch == e.ch, {e.tag, " channel"}, ch, e.ch);
          check(k == e.kind, {e.tag, " outcome"}, k, e.kind);
        end
      end
      pg = grant_o; ps = sel_o; pr = dst_rdy_o;
    end
  end

  task automatic raise(input int r, input logic [AW-1:0] a);
    if (r == 0) dst0_i = a; else dst1_i = a;
    req_i[r] = 1'b1;
    avld_i[r] = 1'b1;
  endtask

  task automatic serve(input int r, input logic [AW-1:0] a);
    raise(r, a);
    do @(negedge clk); while (!dst_rdy_o[r]);
    check(dst_rdy_o == (r == 0 ? 2'b01 : 2'b10), "R4 ready on owner only", dst_rdy_o, r + 1);
    check(sel_o[a] && $onehot(sel_o), "R3 select matches address", sel_o, 1 << a);
    repeat (3) @(negedge clk);
    check(dst_rdy_o[r], "R8 ready held while valid", dst_rdy_o[r], 1);
    req_i[r] = 1'b0;
    avld_i[r] = 1'b0;
    @(negedge clk);
    check(dst_rdy_o == 2'b00 && sel_o == '0, "R8 released after valid drop", dst_rdy_o, 0);
  endtask

  task automatic refuse(input int r, input logic [AW-1:0] a);
    raise(r, a);
    do @(negedge clk); while (!route_err_o);
    req_i[r] = 1'b0;
    avld_i[r] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(grant_o == 2'b00, "R1 grant at reset", grant_o, 0);
    check(sel_o == '0, "R1 select at reset", sel_o, 0);
    check(dst_rdy_o == 2'b00, "R1 ready at reset", dst_rdy_o, 0);
    check(!route_err_o, "R1 error at reset", route_err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R8 single services, including lowest and highest channel
    push(0, 2, K_DONE, "R4"); serve(0, 3'd2);
    push(1, 4, K_DONE, "R4"); serve(1, 3'd4);
    push(0, 0, K_DONE, "R4"); serve(0, 3'd0);

    // R7 addresses beyond the last channel
    push(1, NONE, K_ERR, "R7"); refuse(1, 3'd5);
    push(0, NONE, K_ERR, "R7"); refuse(0, 3'd7);

    // R6 returned address mismatch
    corrupt = 1'b1;
    push(0, 1, K_ERR, "R6"); refuse(0, 3'd1);
    corrupt = 1'b0;
    repeat (2) @(negedge clk);

    // R9 R2 both keep requesting: services alternate
    begin
      automatic bit f;
      raise(0, 3'd1);
      raise(1, 3'd3);
      do @(negedge clk); while (grant_o == 2'b00);
      f = grant_o[1];
      for (int n = 0; n < 4; n++) begin
        automatic bit o = f ^ n[0];
        push(o, o ? 3 : 1, K_DONE, "R9");
      end
      fork
        begin serve(0, 3'd1); serve(0, 3'd1); end
        begin serve(1, 3'd3); serve(1, 3'd3); end
      join
    end
    repeat (2) @(negedge clk);

    // R5 full destination yields to the other requester, then retried
    full[2] = 1'b1;
    push(0, 2, K_YIELD, "R5");
    push(1, 3, K_DONE, "R5");
    push(0, 2, K_DONE, "R5");
    raise(0, 3'd2);
    do @(negedge clk); while (!grant_o[0]);
    fork
      serve(0, 3'd2);
      begin
        raise(1, 3'd3);
        do @(negedge clk); while (!dst_rdy_o[1]);
        full[2] = 1'b0;
        repeat (2) @(negedge clk);
        req_i[1] = 1'b0;
        avld_i[1] = 1'b0;
      end
    join

    repeat (5) @(negedge clk);
    check(q.size() == 0, "all expected routes closed", q.size(), 0);
    finish_run();
  end
endmodule